// File: doc/BRIEF.md
# SDRAM Bank State Protocol Checker

This block is a passive monitor for the command side of a four-bank SDRAM interface. On every rising clock edge it decodes the command lines and keeps an internal state and timer for each bank. It also keeps a device-wide busy window for refresh and mode-register programming, and a spacing timer between row activations. When a command cannot legally be issued in the current state, or arrives before a minimum gap has elapsed, the block raises a one-cycle error pulse. The pulse comes with a code that names the kind of violation and the index of the bank involved.

The block drives nothing onto the memory bus. It is meant to sit beside a memory controller, either in silicon or in a simulation, and catch sequencing bugs. All timing gaps are parameters given in clocks. A rejected command is treated as if it never happened, so one mistake does not cause a cascade of false reports. The data bus and the refresh rate are not checked.

Top module: `sdram_bank_checker`

## Requirements
- R1: A command is decoded only on an edge where `cke`=1 and `csN`=0. Its type comes from {rasN,casN,weN}: 000 mode-set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no-op. An edge without a decoded command produces no error, and neither does a decoded no-op, even during a busy window.
- R2: Each decoded command gives its verdict in the cycle after the edge, on the registered outputs. `errPulse`=1 for exactly that cycle, and `errCode` is 1 (illegal for the bank state), 2 (not all banks idle), 3 (activate spacing) or 4 (device busy). With no error, `errCode`=0 and `errBank`=0. The bank index is `ba` as a binary number 0..3. Reset clears all banks to idle and clears the outputs.
- R3: Activating an idle bank opens it. Activating a bank that is not idle is code 1, and so is a read or write to an idle bank. A rejected command changes no state.
- R4: A read or write is legal T_RCD clocks after the bank was activated. Earlier it is code 1.
- R5: Any activate fewer than T_RRD clocks after the last accepted activate is code 3, on the bank it targets.
- R6: A mode-set or refresh while any bank is not idle is code 2, with `errBank` set to the lowest-numbered bank that is not idle.
- R7: After an accepted refresh, any command other than no-op is code 4 (bank = `ba`) for T_RC-1 clocks; after a mode-set, for T_MRD-1 clocks.
- R8: A read or write with `a10`=1 locks its bank. Read, write, activate and precharge to that bank are code 1 until the burst (BURST_LEN clocks), the write recovery (T_WR, writes only) and T_RP have elapsed. After that the bank is idle.
- R9: During a burst without auto-precharge, a read or write to any open bank is legal and ends that burst. A precharge is legal and leaves the bank precharging for T_RP clocks, during which an activate is code 1.
- R10: A precharge with `a10`=1 applies to all banks. It is code 1, naming the lowest locked bank, if any bank is activating, precharging, recovering from a write, or in an auto-precharge burst.
- R11: Burst stop is code 1 (naming that bank) while any bank is in an auto-precharge burst. Otherwise it is legal and ends open bursts.
- R12: After a write burst ends, a precharge to that bank is code 1 until T_WR clocks have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable as seen on the bus |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Auto-precharge / all-banks flag |
| errPulse | output | 1 | One-cycle violation strobe |
| errCode | output | 3 | Violation class |
| errBank | output | 2 | Bank the violation refers to |

## Verification
The bench targets the edges of every timed window: a read issued one clock before T_RCD expires, a precharge issued one clock before write recovery ends, and an activate issued on the last precharging clock and then on the first idle clock. An off-by-one timer would flag the legal command or let the early one pass. The bench also covers the priority cases: the lowest non-idle bank reported for a mode-set, a precharge-all refused because of an auto-precharge lock, and a burst stop during such a lock. A design that scanned banks in the wrong order, or that let the lock be overridden, would report the wrong bank or no error at all. Finally, the bench checks that rejected activates do not restart the spacing timer and that a reset returns open banks to idle.

// File: rtl/sdchk_pkg.sv
package sdchk_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W = 2;
  localparam int CNT_W = 8;

  typedef enum logic [3:0] {
    B_IDLE, B_ACTV, B_OPEN, B_RD, B_WR, B_RDA, B_WRA, B_WREC, B_WRECA, B_PRE
  } bankSt_e;

  typedef enum logic [2:0] {
    E_NONE = 3'd0, E_STATE = 3'd1, E_ALLIDLE = 3'd2, E_TRRD = 3'd3, E_BUSY = 3'd4
  } errCode_e;

  typedef enum logic [2:0] {
    C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010, C_ACT = 3'b011,
    C_WR  = 3'b100, C_RD  = 3'b101, C_BST = 3'b110, C_NOP = 3'b111
  } cmd_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0] go;
    bankSt_e [NUM_BANKS-1:0] st;
    logic act;
    logic refr;
    logic mrs;
  } strobe_t;
endpackage

// File: rtl/sdchk_banks.sv
module sdchk_banks
  import sdchk_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP = 3,
  parameter int T_RRD = 2,
  parameter int T_RC = 6,
  parameter int T_MRD = 2,
  parameter int T_WR = 2,
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  strobe_t stb,
  output bankSt_e [NUM_BANKS-1:0] effSt,
  output logic devBusy,
  output logic rrdBusy
);
  function automatic logic isTimed(bankSt_e s);
    return !(s == B_IDLE || s == B_OPEN);
  endfunction

  function automatic bankSt_e nextOf(bankSt_e s);
    case (s)
      B_ACTV, B_RD, B_WREC: return B_OPEN;
      B_WR:                 return B_WREC;
      B_WRA:                return B_WRECA;
      B_RDA, B_WRECA:       return B_PRE;
      B_PRE:                return B_IDLE;
      default:              return s;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] loadOf(bankSt_e s);
    case (s)
      B_ACTV:                   return CNT_W'(T_RCD - 1);
      B_RD, B_WR, B_RDA, B_WRA: return CNT_W'(BURST_LEN - 1);
      B_WREC, B_WRECA:          return CNT_W'(T_WR - 1);
      B_PRE:                    return CNT_W'(T_RP - 1);
      default:                  return '0;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    bankSt_e st;
    logic [CNT_W-1:0] cnt;
    logic expired;
    assign expired = isTimed(st) && (cnt == '0);
    assign effSt[g] = expired ? nextOf(st) : st;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        st <= B_IDLE;
        cnt <= '0;
      end else if (stb.go[g]) begin
        st <= stb.st[g];
        cnt <= loadOf(stb.st[g]);
      end else if (expired) begin
        st <= nextOf(st);
        cnt <= loadOf(nextOf(st));
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  logic [CNT_W-1:0] devCnt, rrdCnt;
  assign devBusy = (devCnt != '0);
  assign rrdBusy = (rrdCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devCnt <= '0;
      rrdCnt <= '0;
    end else begin
      if (stb.refr)      devCnt <= CNT_W'(T_RC - 1);
      else if (stb.mrs)  devCnt <= CNT_W'(T_MRD - 1);
      else if (devBusy)  devCnt <= devCnt - 1'b1;
      if (stb.act)       rrdCnt <= CNT_W'(T_RRD - 1);
      else if (rrdBusy)  rrdCnt <= rrdCnt - 1'b1;
    end
  end
endmodule

// File: rtl/sdchk_ctrl.sv
module sdchk_ctrl
  import sdchk_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cke,
  input  logic csN,
  input  logic rasN,
  input  logic casN,
  input  logic weN,
  input  logic [BANK_W-1:0] ba,
  input  logic a10,
  input  bankSt_e [NUM_BANKS-1:0] effSt,
  input  logic devBusy,
  input  logic rrdBusy,
  output strobe_t stb,
  output logic errPulse,
  output logic [2:0] errCode,
  output logic [BANK_W-1:0] errBank
);
  cmd_e cmd;
  logic cmdValid;
  errCode_e code;
  logic [BANK_W-1:0] badBank;
  logic found;

  assign cmd = cmd_e'({rasN, casN, weN});
  assign cmdValid = cke && !csN;

  function automatic logic rwOk(bankSt_e s);
    return s == B_OPEN || s == B_RD || s == B_WR || s == B_WREC;
  endfunction

  function automatic logic preOk(bankSt_e s);
    return s == B_IDLE || s == B_OPEN || s == B_RD || s == B_WR;
  endfunction

  always_comb begin
    stb = '0;
    stb.st = effSt;
    code = E_NONE;
    badBank = ba;
    found = 1'b0;
    if (cmdValid && cmd != C_NOP) begin
      if (devBusy) begin
        code = E_BUSY;
      end else begin
        case (cmd)
          C_MRS, C_REF: begin
            for (int i = NUM_BANKS - 1; i >= 0; i--)
              if (effSt[i] != B_IDLE) begin
                found = 1'b1;
                badBank = BANK_W'(i);
              end
            if (found) code = E_ALLIDLE;
            else if (cmd == C_REF) stb.refr = 1'b1;
            else stb.mrs = 1'b1;
          end
          C_ACT: begin
            if (effSt[ba] != B_IDLE) code = E_STATE;
            else if (rrdBusy) code = E_TRRD;
            else begin
              stb.go[ba] = 1'b1;
              stb.st[ba] = B_ACTV;
              stb.act = 1'b1;
            end
          end
          C_RD, C_WR: begin
            if (!rwOk(effSt[ba])) code = E_STATE;
            else begin
              for (int i = 0; i < NUM_BANKS; i++) begin
                if (BANK_W'(i) == ba) begin
                  stb.go[i] = 1'b1;
                  stb.st[i] = (cmd == C_RD) ? (a10 ? B_RDA : B_RD) : (a10 ? B_WRA : B_WR);
                end else if (effSt[i] == B_RD) begin
                  stb.go[i] = 1'b1;
                  stb.st[i] = B_OPEN;
                end else if (effSt[i] == B_WR) begin
                  stb.go[i] = 1'b1;
                  stb.st[i] = B_WREC;
                end
              end
            end
          end
          C_PRE: begin
            if (a10) begin
              for (int i = NUM_BANKS - 1; i >= 0; i--)
                if (!preOk(effSt[i])) begin
                  found = 1'b1;
                  badBank = BANK_W'(i);
                end
              if (found) code = E_STATE;
              else
                for (int i = 0; i < NUM_BANKS; i++)
                  if (effSt[i] != B_IDLE) begin
                    stb.go[i] = 1'b1;
                    stb.st[i] = B_PRE;
                  end
            end else if (!preOk(effSt[ba])) begin
              code = E_STATE;
            end else if (effSt[ba] != B_IDLE) begin
              stb.go[ba] = 1'b1;
              stb.st[ba] = B_PRE;
            end
          end
          C_BST: begin
            for (int i = NUM_BANKS - 1; i >= 0; i--)
              if (effSt[i] == B_RDA || effSt[i] == B_WRA) begin
                found = 1'b1;
                badBank = BANK_W'(i);
              end
            if (found) code = E_STATE;
            else
              for (int i = 0; i < NUM_BANKS; i++)
                if (effSt[i] == B_RD || effSt[i] == B_WR) begin
                  stb.go[i] = 1'b1;
                  stb.st[i] = (effSt[i] == B_RD) ? B_OPEN : B_WREC;
                end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errPulse <= 1'b0;
      errCode <= 3'd0;
      errBank <= '0;
    end else begin
      errPulse <= (code != E_NONE);
      errCode <= code;
      errBank <= (code != E_NONE) ? badBank : '0;
    end
  end
endmodule

// File: rtl/sdram_bank_checker.sv
module sdram_bank_checker
  import sdchk_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP = 3,
  parameter int T_RRD = 2,
  parameter int T_RC = 6,
  parameter int T_MRD = 2,
  parameter int T_WR = 2,
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic cke,
  input  logic csN,
  input  logic rasN,
  input  logic casN,
  input  logic weN,
  input  logic [1:0] ba,
  input  logic a10,
  output logic errPulse,
  output logic [2:0] errCode,
  output logic [1:0] errBank
);
  strobe_t stb;
  bankSt_e [NUM_BANKS-1:0] effSt;
  logic devBusy, rrdBusy;

  sdchk_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .a10(a10), .effSt(effSt), .devBusy(devBusy),
    .rrdBusy(rrdBusy), .stb(stb), .errPulse(errPulse), .errCode(errCode),
    .errBank(errBank)
  );

  sdchk_banks #(
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RRD(T_RRD), .T_RC(T_RC), .T_MRD(T_MRD),
    .T_WR(T_WR), .BURST_LEN(BURST_LEN)
  ) banksI (
    .clk(clk), .rstN(rstN), .stb(stb), .effSt(effSt), .devBusy(devBusy),
    .rrdBusy(rrdBusy)
  );
endmodule

// File: rtl/sdchk_props.sv
module sdchk_props #(
  parameter int T_MRD = 2,
  parameter int T_RRD = 2
) (
  input logic clk,
  input logic rstN,
  input logic cke,
  input logic csN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic [1:0] ba,
  input logic a10,
  input logic errPulse,
  input logic [2:0] errCode,
  input logic [1:0] errBank
);
  logic cmdValid, isNop, isAct, isMrs;
  assign cmdValid = cke && !csN;
  assign isNop = cmdValid && rasN && casN && weN;
  assign isAct = cmdValid && !rasN && casN && weN;
  assign isMrs = cmdValid && !rasN && !casN && !weN;

  // R1
  ignored_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> !errPulse);

  // R1
  nop_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    isNop |=> !errPulse);

  // R2
  code_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> errCode != 3'd0);

  // R2
  quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !errPulse |-> (errCode == 3'd0 && errBank == 2'd0));

  // R5
  act_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (T_RRD >= 2) && isAct ##1 (!errPulse && isAct) |=> errPulse);

  // R7
  mrs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (T_MRD >= 2) && isMrs ##1 (!errPulse && cmdValid && !isNop)
      |=> (errPulse && errCode == 3'd4));

  wire unusedA10 = a10 ^ ba[0];
endmodule

bind sdram_bank_checker sdchk_props #(.T_MRD(T_MRD), .T_RRD(T_RRD)) propsI (
  .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
  .weN(weN), .ba(ba), .a10(a10), .errPulse(errPulse), .errCode(errCode),
  .errBank(errBank)
);

// File: tb/sdram_bank_checker_test.sv
module sdram_bank_checker_test;
  localparam int T_RCD = 3, T_RP = 3, T_RRD = 2, T_RC = 6, T_MRD = 2, T_WR = 2, BL = 4;
  localparam logic [2:0] MRS = 3'b000, REF = 3'b001, PRE = 3'b010, ACT = 3'b011,
                         WR = 3'b100, RD = 3'b101, BST = 3'b110, NOP = 3'b111;

  typedef struct packed {
    logic cke; logic csN; logic [2:0] op; logic [1:0] b; logic a;
    logic e; logic [2:0] cd; logic [1:0] bk; logic [3:0] rq;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VEC [NV] = '{
    '{1,0,NOP,0,0, 0,0,0, 1},  // 0  R1 no-op
    '{1,0,RD ,0,0, 1,1,0, 3},  // 1  R3 read idle bank
    '{1,0,ACT,0,0, 0,0,0, 3},  // 2  R3 open bank0
    '{1,0,ACT,1,0, 1,3,1, 5},  // 3  R5 spacing
    '{1,0,RD ,0,0, 1,1,0, 4},  // 4  R4 read before T_RCD
    '{1,0,ACT,0,0, 1,1,0, 3},  // 5  R3 activate open bank
    '{1,0,ACT,1,0, 0,0,0, 5},  // 6  R5 spacing met
    '{1,0,RD ,0,0, 0,0,0, 4},  // 7  R4 read at T_RCD
    '{1,0,WR ,0,0, 0,0,0, 9},  // 8  R9 interrupt read
    '{1,0,PRE,0,0, 0,0,0, 9},  // 9  R9 precharge in burst
    '{1,0,ACT,0,0, 1,1,0, 9},  // 10 R9 precharging
    '{1,0,MRS,0,0, 1,2,0, 6},  // 11 R6
    '{1,0,ACT,0,0, 0,0,0, 9},  // 12 R9 idle after T_RP
    '{1,0,WR ,1,0, 0,0,0, 12}, // 13 R12 write bank1
    '{1,0,NOP,0,0, 0,0,0, 1},  // 14
    '{1,0,NOP,0,0, 0,0,0, 1},  // 15
    '{1,0,NOP,0,0, 0,0,0, 1},  // 16
    '{1,0,PRE,1,0, 1,1,1, 12}, // 17 R12 recovering
    '{1,0,PRE,1,0, 1,1,1, 12}, // 18 R12 recovering
    '{1,0,PRE,1,0, 0,0,0, 12}, // 19 R12 recovery done
    '{1,0,RD ,0,1, 0,0,0, 8},  // 20 R8 read auto-precharge
    '{1,0,BST,0,0, 1,1,0, 11}, // 21 R11 stop during lock
    '{1,0,PRE,0,0, 1,1,0, 8},  // 22 R8
    '{1,0,PRE,2,1, 1,1,0, 10}, // 23 R10 all, bank0 locked
    '{1,0,ACT,0,0, 1,1,0, 8},  // 24 R8
    '{1,0,REF,0,0, 1,2,0, 6},  // 25 R6
    '{1,0,ACT,0,0, 1,1,0, 8},  // 26 R8 last precharging clock
    '{1,0,ACT,0,0, 0,0,0, 8},  // 27 R8 idle again
    '{1,0,ACT,2,0, 1,3,2, 5},  // 28 R5
    '{1,0,ACT,2,0, 0,0,0, 5},  // 29 R5
    '{1,0,RD ,0,0, 0,0,0, 9},  // 30 R9
    '{1,0,BST,0,0, 0,0,0, 11}, // 31 R11 legal stop
    '{1,0,PRE,3,1, 0,0,0, 10}, // 32 R10 all banks
    '{1,0,RD ,2,0, 1,1,2, 10}, // 33 R10 bank2 precharging
    '{1,0,REF,0,0, 1,2,0, 6},  // 34 R6
    '{1,0,REF,0,0, 0,0,0, 7},  // 35 R7 refresh
    '{1,0,ACT,3,0, 1,4,3, 7},  // 36 R7 busy
    '{1,0,NOP,0,0, 0,0,0, 1},  // 37 R1 no-op while busy
    '{1,1,RD ,0,0, 0,0,0, 1},  // 38 R1 deselected
    '{0,0,ACT,0,0, 0,0,0, 1},  // 39 R1 cke low
    '{1,0,REF,1,0, 1,4,1, 7},  // 40 R7 last busy clock
    '{1,0,MRS,0,0, 0,0,0, 7},  // 41 R7 mode-set
    '{1,0,ACT,1,0, 1,4,1, 7},  // 42 R7
    '{1,0,ACT,1,0, 0,0,0, 7}   // 43 R7 window over
  };

  logic clk = 0, rstN = 0, cke = 1, csN = 1, rasN = 1, casN = 1, weN = 1, a10 = 0;
  logic [1:0] ba = 0;
  logic errPulse;
  logic [2:0] errCode;
  logic [1:0] errBank;
  int checks = 0, failures = 0, cycles = 0;

  always #10 clk = ~clk;

  sdram_bank_checker #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RRD(T_RRD), .T_RC(T_RC),
    .T_MRD(T_MRD), .T_WR(T_WR), .BURST_LEN(BL)) uut (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .a10(a10), .errPulse(errPulse), .errCode(errCode),
    .errBank(errBank));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      failures++;
      $display("FAIL watchdog: got cycles=%0d expected <= 5000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic doCmd(input logic k, input logic c, input logic [2:0] op,
                       input logic [1:0] b, input logic a);
    cke = k; csN = c; {rasN, casN, weN} = op; ba = b; a10 = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic e, input logic [2:0] cd, input logic [1:0] bk);
    checks++;
    if ({errPulse, errCode, errBank} !== {e, cd, bk}) begin
      failures++;
      $display("FAIL %s: got err=%0b code=%0d bank=%0d expected err=%0b code=%0d bank=%0d",
               rq, errPulse, errCode, errBank, e, cd, bk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    chk("R2 reset outputs", 0, 0, 0);
    for (int i = 0; i < NV; i++) begin
      doCmd(VEC[i].cke, VEC[i].csN, VEC[i].op, VEC[i].b, VEC[i].a);
      chk($sformatf("R%0d row %0d", VEC[i].rq, i), VEC[i].e, VEC[i].cd, VEC[i].bk);
    end
    // R2 reset returns the open bank1 to idle
    rstN = 0;
    doCmd(1, 1, NOP, 0, 0);
    chk("R2 outputs in reset", 0, 0, 0);
    rstN = 1;
    doCmd(1, 0, RD, 1, 0);
    chk("R2 bank idle after reset", 1, 1, 1);
    // R8 write with auto-precharge on bank3
    doCmd(1, 0, ACT, 3, 0);
    chk("R8 open bank3", 0, 0, 0);
    for (int i = 0; i < T_RCD - 1; i++) doCmd(1, 0, NOP, 0, 0);
    doCmd(1, 0, WR, 3, 1);
    chk("R8 write auto-precharge", 0, 0, 0);
    doCmd(1, 0, RD, 3, 0);
    chk("R8 read during lock", 1, 1, 3);
    for (int i = 0; i < BL + T_WR + T_RP - 3; i++) doCmd(1, 0, NOP, 0, 0);
    doCmd(1, 0, ACT, 3, 0);
    chk("R8 activate one clock early", 1, 1, 3);
    doCmd(1, 0, ACT, 3, 0);
    chk("R8 activate after lock", 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule